// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is the register-transfer datapath of a processor built around a single internal bus. The program counter, memory address register, memory data register, instruction register, a four-entry general register file, an ALU operand register Y and an ALU result register Z all sit on that bus. Each cycle an external controller asserts one out-enable strobe to pick the bus driver. It also asserts any number of in-enable strobes to pick the registers that latch the bus value at the next clock edge. Sequencing, instruction decode and memory writes belong to the controller and the memory system, not to this block.

The ALU takes one operand from Y, or from a forced zero when the Y-clear strobe is high. It takes the other operand straight from the bus. Its result is registered in Z only when Z's in-enable is asserted. Forcing the Y operand to zero and setting carry-in turns the add path into an incrementer for the program counter, so no separate incrementer is needed. The condition flags (negative, zero, overflow) follow every result written into Z. The memory side has an address driven from the memory address register, a read request passed straight through, read data, and a completion signal that loads the memory data register. The opcode bits of the instruction register are brought out for the controller's decoder.

Top module: `sbus_datapath`

## Requirements
- R1: While reset is high and on the first cycle after it, every register (PC, MAR, MDR, IR, the four general registers, Y, Z) and all three flags read zero, so mem_addr is 0 and flag_n, flag_z and flag_v are 0.
- R2: At most one out-enable (pc_oe, mdr_oe, irf_oe, gpr_oe, z_oe) is asserted in a cycle. The bus then carries exactly the selected source, and when none is asserted it carries 0.
- R3: The ALU computes from A = (y_clr ? 0 : Y) and B = bus. Z takes the result at the clock edge only when z_le is high and otherwise keeps its value. The alu_op encoding is 0 add (A+B+cin), 1 subtract (A-B), 2 bitwise AND, 3 bitwise OR.
- R4: With pc_oe, y_clr, cin = 1, alu_op = 0 and z_le, Z receives PC + 1 modulo 2^16. Z then drives PC through z_oe and pc_le.
- R5: MDR loads mem_rdata at a clock edge where mem_mfc is high and holds otherwise. mdr_oe places MDR on the bus.
- R6: The instruction word is 16 bits: opcode in bits 15:12, register select in bits 11:10 and address/offset in bits 9:0. irf_oe drives bits 9:0 sign-extended from bit 9 onto the bus, and ir_opcode shows IR bits 15:12.
- R7: gpr_oe drives, and gpr_le writes, the general register chosen by IR bits 11:10.
- R8: flag_n, flag_z and flag_v update only at an edge where z_le is high. They then show bit 15 of the value written into Z, whether that value is zero, and signed two's-complement overflow for add or subtract (0 for AND and OR).
- R9: mem_addr shows the MAR continuously. MAR loads the bus when mar_le is high. mem_rd equals rd_req in the same cycle.
- R10: A branch target is formed by loading Y from PC, then adding the sign-extended IR offset on the bus into Z, then moving Z to PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_oe | input | 1 | PC drives the bus |
| pc_le | input | 1 | PC latches the bus |
| mar_le | input | 1 | MAR latches the bus |
| mdr_oe | input | 1 | MDR drives the bus |
| ir_le | input | 1 | IR latches the bus |
| irf_oe | input | 1 | Sign-extended IR address field drives the bus |
| gpr_oe | input | 1 | Selected general register drives the bus |
| gpr_le | input | 1 | Selected general register latches the bus |
| y_le | input | 1 | Y latches the bus |
| y_clr | input | 1 | Forces the ALU Y operand to zero this cycle |
| cin | input | 1 | ALU carry-in for add |
| alu_op | input | 2 | ALU function: 0 add, 1 sub, 2 and, 3 or |
| z_le | input | 1 | Z latches the ALU result and flags update |
| z_oe | input | 1 | Z drives the bus |
| rd_req | input | 1 | Memory read request from the controller |
| mem_rdata | input | 16 | Memory read data |
| mem_mfc | input | 1 | Memory function complete, loads MDR |
| mem_addr | output | 16 | Memory address from MAR |
| mem_rd | output | 1 | Memory read request to memory |
| ir_opcode | output | 4 | IR bits 15:12 for the controller |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bound checker watches on every cycle that at most one source drives the bus and that an undriven bus is zero. It also checks that MAR follows the bus only when loaded and that Z and the flags stay still unless z_le is high. Further per-cycle checks cover the zero and negative flags against the value in Z, and the increment path, which must yield PC + 1. Other behaviour can only be shown by the bench's scenarios. That covers the exact arithmetic and overflow of each ALU function and the sign extension of negative offsets. It also covers the register-field selection of the general registers, MDR ignoring read data without a completion strobe, and the complete fetch, add and branch sequences, all observed through mem_addr and the flags.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    parameter int WORD_W  = 16;
    parameter int NREG    = 4;
    parameter int OFS_W   = 10;
    parameter int SEL_LSB = 10;
    parameter int SEL_W   = $clog2(NREG);
    parameter int OPC_LSB = SEL_LSB + SEL_W;
    parameter int OPC_W   = WORD_W - OPC_LSB;
    parameter int NSRC    = 5;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_OR  = 2'd3
    } alu_op_e;

    typedef struct packed {
        word_t value;
        logic  neg;
        logic  zero;
        logic  ovf;
    } alu_res_t;

    function automatic word_t sext_offset(input logic [OFS_W-1:0] ofs);
        return {{(WORD_W-OFS_W){ofs[OFS_W-1]}}, ofs};
    endfunction

endpackage

// File: rtl/sbus_alu.sv
module sbus_alu
    import sbus_pkg::*;
(
    input  word_t    opa,
    input  word_t    opb,
    input  logic     cin,
    input  alu_op_e  op,
    output alu_res_t res
);
    word_t eff_b;
    word_t sum;
    logic  arith;

    always_comb begin
        eff_b = (op == ALU_SUB) ? ~opb : opb;
        arith = (op == ALU_ADD) || (op == ALU_SUB);
        sum   = opa + eff_b + {{(WORD_W-1){1'b0}}, (op == ALU_SUB) ? 1'b1 : cin};
        unique case (op)
            ALU_AND: res.value = opa & opb;
            ALU_OR:  res.value = opa | opb;
            default: res.value = sum;
        endcase
        res.neg  = res.value[WORD_W-1];
        res.zero = (res.value == '0);
        res.ovf  = arith && (opa[WORD_W-1] == eff_b[WORD_W-1])
                         && (sum[WORD_W-1] != opa[WORD_W-1]);
    end
endmodule

// File: rtl/sbus_bus_mux.sv
module sbus_bus_mux
    import sbus_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]        oe,
    input  logic [N*WORD_W-1:0] src,
    output word_t               bus
);
    word_t masked [N];

    for (genvar i = 0; i < N; i++) begin : g_src
        assign masked[i] = oe[i] ? src[i*WORD_W +: WORD_W] : '0;
    end

    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) begin
            bus = bus | masked[i];
        end
    end
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile
    import sbus_pkg::*;
#(
    parameter int DEPTH = NREG,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] sel,
    input  word_t         wdata,
    output word_t         rdata
);
    word_t regs [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (we && (sel == AW'(i))) begin
                regs[i] <= wdata;
            end
        end
    end

    assign rdata = regs[sel];
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
    import sbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pc_oe,
    input  logic              pc_le,
    input  logic              mar_le,
    input  logic              mdr_oe,
    input  logic              ir_le,
    input  logic              irf_oe,
    input  logic              gpr_oe,
    input  logic              gpr_le,
    input  logic              y_le,
    input  logic              y_clr,
    input  logic              cin,
    input  logic [1:0]        alu_op,
    input  logic              z_le,
    input  logic              z_oe,
    input  logic              rd_req,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_mfc,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic [OPC_W-1:0]  ir_opcode,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v
);
    localparam int SRC_BITS = NSRC * WORD_W;

    word_t    pc_q, mar_q, mdr_q, ir_q, y_q, z_q;
    word_t    bus, gpr_rd, alu_a;
    alu_res_t alu_res;
    logic [NSRC-1:0]     oe_vec;
    logic [SRC_BITS-1:0] src_vec;

    assign oe_vec  = {z_oe, gpr_oe, irf_oe, mdr_oe, pc_oe};
    assign src_vec = {z_q, gpr_rd, sext_offset(ir_q[OFS_W-1:0]), mdr_q, pc_q};

    sbus_bus_mux #(.N(NSRC)) u_mux (
        .oe  (oe_vec),
        .src (src_vec),
        .bus (bus)
    );

    sbus_regfile #(.DEPTH(NREG)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (gpr_le),
        .sel   (ir_q[SEL_LSB +: SEL_W]),
        .wdata (bus),
        .rdata (gpr_rd)
    );

    assign alu_a = y_clr ? '0 : y_q;

    sbus_alu u_alu (
        .opa (alu_a),
        .opb (bus),
        .cin (cin),
        .op  (alu_op_e'(alu_op)),
        .res (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            mar_q  <= '0;
            mdr_q  <= '0;
            ir_q   <= '0;
            y_q    <= '0;
            z_q    <= '0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            flag_v <= 1'b0;
        end else begin
            if (pc_le)   pc_q  <= bus;
            if (mar_le)  mar_q <= bus;
            if (mem_mfc) mdr_q <= mem_rdata;
            if (ir_le)   ir_q  <= bus;
            if (y_le)    y_q   <= bus;
            if (z_le) begin
                z_q    <= alu_res.value;
                flag_n <= alu_res.neg;
                flag_z <= alu_res.zero;
                flag_v <= alu_res.ovf;
            end
        end
    end

    assign mem_addr  = mar_q;
    assign mem_rd    = rd_req;
    assign ir_opcode = ir_q[OPC_LSB +: OPC_W];
endmodule

// File: rtl/sbus_dp_chk.sv
module sbus_dp_chk
    import sbus_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] oe_vec,
    input word_t           bus,
    input logic            mar_le,
    input word_t           mem_addr,
    input logic            z_le,
    input word_t           z_q,
    input word_t           pc_q,
    input logic            pc_oe,
    input logic            y_clr,
    input logic            cin,
    input logic [1:0]      alu_op,
    input logic            flag_n,
    input logic            flag_z,
    input logic            flag_v
);
    // R2
    one_driver_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(oe_vec));

    // R2
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (oe_vec == '0) |-> (bus == '0));

    // R9
    mar_follow_chk: assert property (@(posedge clk) disable iff (rst)
        mar_le |=> (mem_addr == $past(bus)));

    // R9
    mar_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mar_le |=> $stable(mem_addr));

    // R3
    z_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !z_le |=> $stable(z_q));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !z_le |=> $stable({flag_n, flag_z, flag_v}));

    // R8
    flag_value_chk: assert property (@(posedge clk) disable iff (rst)
        z_le |=> ((flag_z == (z_q == '0)) && (flag_n == z_q[WORD_W-1])));

    // R4
    pc_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (z_le && pc_oe && y_clr && cin && (alu_op == 2'd0))
        |=> (z_q == $past(pc_q) + 1'b1));
endmodule

bind sbus_datapath sbus_dp_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .oe_vec   (oe_vec),
    .bus      (bus),
    .mar_le   (mar_le),
    .mem_addr (mem_addr),
    .z_le     (z_le),
    .z_q      (z_q),
    .pc_q     (pc_q),
    .pc_oe    (pc_oe),
    .y_clr    (y_clr),
    .cin      (cin),
    .alu_op   (alu_op),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_v   (flag_v)
);

// File: tb/sim_sbus_datapath.sv
`timescale 1ns/1ps
module sim_sbus_datapath;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pc_oe, pc_le, mar_le, mdr_oe, ir_le, irf_oe, gpr_oe, gpr_le;
    logic y_le, y_clr, cin, z_le, z_oe, rd_req, mem_mfc;
    logic [1:0]  alu_op;
    logic [15:0] mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [3:0]  ir_opcode;
    logic        flag_n, flag_z, flag_v;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    logic [15:0] m_pc, m_mar, m_mdr, m_ir, m_y, m_z;
    logic [15:0] m_r [4];
    logic        m_n, m_zf, m_v;

    always #4 clk = ~clk;

    sbus_datapath u0 (
        .clk(clk), .rst(rst), .pc_oe(pc_oe), .pc_le(pc_le), .mar_le(mar_le),
        .mdr_oe(mdr_oe), .ir_le(ir_le), .irf_oe(irf_oe), .gpr_oe(gpr_oe),
        .gpr_le(gpr_le), .y_le(y_le), .y_clr(y_clr), .cin(cin), .alu_op(alu_op),
        .z_le(z_le), .z_oe(z_oe), .rd_req(rd_req), .mem_rdata(mem_rdata),
        .mem_mfc(mem_mfc), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .ir_opcode(ir_opcode), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        {pc_oe, pc_le, mar_le, mdr_oe, ir_le, irf_oe, gpr_oe, gpr_le} = '0;
        {y_le, y_clr, cin, z_le, z_oe, rd_req, mem_mfc} = '0;
        alu_op = 2'd0;
    endtask

    task automatic model_step();
        logic [15:0] b, a, r;
        int sa, sb, sr;
        if (rst) begin
            m_pc = 0; m_mar = 0; m_mdr = 0; m_ir = 0; m_y = 0; m_z = 0;
            for (int i = 0; i < 4; i++) m_r[i] = 0;
            m_n = 0; m_zf = 0; m_v = 0;
            return;
        end
        b = 16'h0;
        if (pc_oe)  b = m_pc;
        if (mdr_oe) b = m_mdr;
        if (irf_oe) b = {{6{m_ir[9]}}, m_ir[9:0]};
        if (gpr_oe) b = m_r[m_ir[11:10]];
        if (z_oe)   b = m_z;
        a  = y_clr ? 16'h0 : m_y;
        sa = int'($signed(a));
        sb = int'($signed(b));
        case (alu_op)
            2'd0: begin sr = sa + sb + int'(cin); r = 16'(sr); end
            2'd1: begin sr = sa - sb;             r = 16'(sr); end
            2'd2: begin r = a & b; sr = int'($signed(r)); end
            default: begin r = a | b; sr = int'($signed(r)); end
        endcase
        if (z_le) begin
            m_n  = r[15];
            m_zf = (r == 16'h0);
            m_v  = (alu_op < 2'd2) && (sr != int'($signed(r)));
            m_z  = r;
        end
        if (mem_mfc) m_mdr = mem_rdata;
        if (gpr_le)  m_r[m_ir[11:10]] = b;
        if (pc_le)   m_pc = b;
        if (mar_le)  m_mar = b;
        if (ir_le)   m_ir = b;
        if (y_le)    m_y = b;
    endtask

    // one clock: model advances at the edge, outputs compared mid-low phase
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R9 mem_addr vs model", mem_addr, m_mar);
        chk("R8 flags vs model", {13'h0, flag_n, flag_z, flag_v}, {13'h0, m_n, m_zf, m_v});
        chk("R6 opcode vs model", {12'h0, ir_opcode}, {12'h0, m_ir[15:12]});
        idle();
    endtask

    task automatic fetch(input logic [15:0] word);
        pc_oe = 1; mar_le = 1; y_clr = 1; cin = 1; alu_op = 2'd0; z_le = 1; rd_req = 1;
        cyc();
        z_oe = 1; pc_le = 1; mem_rdata = word; mem_mfc = 1;
        cyc();
        mdr_oe = 1; ir_le = 1;
        cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle();
        mem_rdata = 16'h0;
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R1 reset state
        chk("R1 mem_addr after reset", mem_addr, 16'h0000);
        chk("R1 flags after reset", {13'h0, flag_n, flag_z, flag_v}, 16'h0);

        // R9 read request passes straight through
        rd_req = 1;
        #1;
        chk("R9 mem_rd follows rd_req", {15'h0, mem_rd}, 16'h1);
        cyc();

        // R4 fetch of ADD R1,0x005 ; PC becomes 1
        fetch(16'h1405);
        chk("R6 ir_opcode", {12'h0, ir_opcode}, 16'h0001);
        pc_oe = 1; mar_le = 1; cyc();
        chk("R4 PC incremented", mem_addr, 16'h0001);

        // R5 MDR load on completion, then into R1 (R7)
        mem_rdata = 16'h7FFF; mem_mfc = 1; cyc();
        mem_rdata = 16'h1234; cyc();                 // no completion: ignored
        mdr_oe = 1; gpr_le = 1; cyc();
        // R6 positive address field to MAR
        irf_oe = 1; mar_le = 1; cyc();
        chk("R6 address field to MAR", mem_addr, 16'h0005);
        gpr_oe = 1; mar_le = 1; cyc();
        chk("R5 MDR ignores data without mfc", mem_addr, 16'h7FFF);
        // R3 add 0x7FFF + 1 with overflow
        gpr_oe = 1; y_le = 1; mem_rdata = 16'h0001; mem_mfc = 1; cyc();
        mdr_oe = 1; alu_op = 2'd0; z_le = 1; cyc();
        chk("R8 add overflow flags NZV", {13'h0, flag_n, flag_z, flag_v}, 16'h0005);
        z_oe = 1; gpr_le = 1; cyc();
        gpr_oe = 1; mar_le = 1; cyc();
        chk("R7 sum written to R1", mem_addr, 16'h8000);

        // R2 idle bus reads zero
        mar_le = 1; cyc();
        chk("R2 undriven bus is zero", mem_addr, 16'h0000);

        // R10 branch by -3 from PC=1
        mem_rdata = 16'h83FD; mem_mfc = 1; cyc();
        mdr_oe = 1; ir_le = 1; cyc();
        irf_oe = 1; mar_le = 1; cyc();
        chk("R6 negative offset sign-extended", mem_addr, 16'hFFFD);
        pc_oe = 1; y_le = 1; cyc();
        irf_oe = 1; alu_op = 2'd0; z_le = 1; cyc();
        chk("R8 branch add flags", {13'h0, flag_n, flag_z, flag_v}, 16'h0004);
        z_oe = 1; pc_le = 1; cyc();
        pc_oe = 1; mar_le = 1; cyc();
        chk("R10 branch target in PC", mem_addr, 16'hFFFE);

        // R3/R8 subtract to zero, Y = 0xFFFE
        pc_oe = 1; y_le = 1; cyc();
        pc_oe = 1; alu_op = 2'd1; z_le = 1; cyc();
        chk("R8 sub zero flags", {13'h0, flag_n, flag_z, flag_v}, 16'h0002);
        irf_oe = 1; alu_op = 2'd3; cyc();            // no z_le: no effect
        chk("R8 flags hold without z_le", {13'h0, flag_n, flag_z, flag_v}, 16'h0002);
        z_oe = 1; mar_le = 1; cyc();
        chk("R3 Z holds without z_le", mem_addr, 16'h0000);

        // R3 logic functions
        irf_oe = 1; alu_op = 2'd2; z_le = 1; cyc();
        z_oe = 1; mar_le = 1; cyc();
        chk("R3 AND result", mem_addr, 16'hFFFC);
        chk("R8 AND clears V", {15'h0, flag_v}, 16'h0000);
        irf_oe = 1; alu_op = 2'd3; z_le = 1; cyc();
        z_oe = 1; mar_le = 1; cyc();
        chk("R3 OR result", mem_addr, 16'hFFFF);
        chk("R8 OR negative", {15'h0, flag_n}, 16'h0001);

        // R1 reset again clears everything
        rst = 1; cyc(); cyc();
        rst = 0; cyc();
        chk("R1 mem_addr after second reset", mem_addr, 16'h0000);
        pc_oe = 1; mar_le = 1; cyc();
        chk("R1 PC cleared by reset", mem_addr, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule